// File: doc/BRIEF.md
# Interrupt message request encoder

The block takes interrupt requests from application logic, packs each into a single 64-bit word, and issues the words on a valid/ready stream. Every word holds the interrupt vector number, the traffic class and the message data in fixed bit fields. Requests are first written into a small in-order queue. The queue lets the application keep issuing requests while the consumer stalls, and it holds them until they can be sent.

The consumer may deassert ready at any time. Ready is treated as a late indication. The block may keep valid high for a bounded number of cycles after ready falls, and each word it shows in those cycles counts as taken. Once that grace window has passed, valid stays low until ready returns. When the queue is full, the block raises a busy output so that no request is lost.

Top module: `msi_req_encoder`

## Requirements
- R1: The outgoing word carries the vector number in bits 4:0, the traffic class in bits 7:5 and the message data in bits 63:8.
- R2: While ready is high, valid is high exactly when the queue holds at least one request. A request taken at a clock edge is presented from the next cycle on.
- R3: In any cycle where ready is low and was also low in the three preceding cycles, valid is low.
- R4: A word presented with ready low in the first, second or third consecutive low cycle counts as transferred. The next queued word follows in the next cycle.
- R5: Busy is high exactly when the queue holds DEPTH (default 4) requests. A request offered while busy is high is not taken.
- R6: Words leave in arrival order, and a new word may be transferred on every consecutive cycle.
- R7: Asynchronous reset empties the queue, deasserts valid and busy, and discards any pending requests.
- R8: When ready returns high after the window has expired, valid rises in that same cycle if the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Application offers a request |
| req_vec_i | input | 5 | Interrupt vector number |
| req_tc_i | input | 3 | Traffic class |
| req_data_i | input | 56 | Message data |
| busy_o | output | 1 | Queue full, request not taken |
| msg_valid_o | output | 1 | Outgoing word is valid |
| msg_data_o | output | 64 | Packed outgoing word |
| msg_ready_i | input | 1 | Consumer ready |

## Verification
On every cycle the assertions check four things: valid falls after the grace window, the queue never takes a request while full, the queue never releases a word while empty, and a waiting head word stays stable. The bench scenarios cover the rest. They show the field packing, the exact count of words that drain during a grace window, ordering across back-pressure, and the loss of pending requests on reset. A reference queue in the bench follows every transfer under irregular ready and request patterns.

// File: rtl/msi_enc_pkg.sv
package msi_enc_pkg;
  localparam int VEC_W  = 5;
  localparam int TC_W   = 3;
  localparam int DATA_W = 56;
  localparam int WORD_W = VEC_W + TC_W + DATA_W;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [TC_W-1:0]   tc;
    logic [VEC_W-1:0]  vec;
  } msi_word_t;

  function automatic msi_word_t pack_word(logic [VEC_W-1:0] vec,
                                          logic [TC_W-1:0] tc,
                                          logic [DATA_W-1:0] data);
    msi_word_t w;
    w.vec  = vec;
    w.tc   = tc;
    w.data = data;
    return w;
  endfunction
endpackage

// File: rtl/msi_req_fifo.sv
module msi_req_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  assign full_o  = (cnt_q == FULL);
  assign empty_o = (cnt_q == '0);
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/msi_lag_tracker.sv
module msi_lag_tracker #(
  parameter int MAX_LAG = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  output logic open_o
);
  localparam int LW = $clog2(MAX_LAG + 1);
  localparam logic [LW-1:0] SAT = LW'(MAX_LAG);

  // consecutive low-ready cycles before the current one, saturating
  logic [LW-1:0] lag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           lag_q <= '0;
    else if (ready_i)      lag_q <= '0;
    else if (lag_q != SAT) lag_q <= lag_q + 1'b1;
  end

  assign open_o = ready_i || (lag_q < SAT);
endmodule

// File: rtl/msi_req_encoder.sv
module msi_req_encoder
  import msi_enc_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int MAX_LAG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  input  logic [TC_W-1:0]   req_tc_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              msg_valid_o,
  output logic [WORD_W-1:0] msg_data_o,
  input  logic              msg_ready_i
);
  msi_word_t   in_word;
  logic        push, pop, full, empty, win_open;
  logic [WORD_W-1:0] head;

  assign in_word = pack_word(req_vec_i, req_tc_i, req_data_i);
  assign push    = req_valid_i && !full;
  assign pop     = msg_valid_o;   // every presented word is taken

  msi_req_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (in_word),
    .pop_i   (pop),
    .rdata_o (head),
    .full_o  (full),
    .empty_o (empty)
  );

  msi_lag_tracker #(.MAX_LAG(MAX_LAG)) i_lag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (msg_ready_i),
    .open_o  (win_open)
  );

  assign busy_o      = full;
  assign msg_valid_o = !empty && win_open;
  assign msg_data_o  = head;

  // independent low-ready counter for the window check
  localparam int GW = $clog2(MAX_LAG + 1);
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= '0;
    else if (msg_ready_i)            gap_q <= '0;
    else if (gap_q != GW'(MAX_LAG))  gap_q <= gap_q + 1'b1;
  end

  p_valid_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_ready_i && gap_q == GW'(MAX_LAG)) |-> !msg_valid_o);
  p_head_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msg_valid_o && !empty) |=> $stable(msg_data_o));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r7: assert (!msg_valid_o && !busy_o);
    end
  end
endmodule

// File: tb/test_msi_req_encoder.sv
module test_msi_req_encoder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_ni, req_valid, busy, msg_valid, msg_ready;
  logic [4:0]  req_vec;
  logic [2:0]  req_tc;
  logic [55:0] req_data;
  logic [63:0] msg_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  msi_req_encoder i_msi_req_encoder (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_vec_i(req_vec),
    .req_tc_i(req_tc), .req_data_i(req_data), .busy_o(busy),
    .msg_valid_o(msg_valid), .msg_data_o(msg_data), .msg_ready_i(msg_ready)
  );

  localparam int NV = 8;
  localparam logic [4:0]  T_VEC [NV] = '{5'd0, 5'd31, 5'd0, 5'd31, 5'd5, 5'd10, 5'd1, 5'd16};
  localparam logic [2:0]  T_TC  [NV] = '{3'd0, 3'd0, 3'd7, 3'd7, 3'd2, 3'd5, 3'd1, 3'd4};
  localparam logic [55:0] T_DAT [NV] = '{56'h0, 56'h0, 56'h0, 56'hFFFFFFFFFFFFFF,
                                         56'h123456789ABCDE, 56'hA5A5A5A5A5A5A5,
                                         56'h1, 56'h80000000000000};
  localparam logic [63:0] T_EXP [NV] = '{64'h0, 64'h1F, 64'hE0, 64'hFFFFFFFFFFFFFFFF,
                                         64'h123456789ABCDE45, 64'hA5A5A5A5A5A5A5AA,
                                         64'h121, 64'h8000000000000090};

  logic [63:0] mq[$];
  int lag = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_ni) begin
      lag = 0;
    end else begin
      bit win, exp_v;
      string lbl;
      win   = msg_ready || lag < 3;
      exp_v = (mq.size() != 0) && win;
      chk(busy == (mq.size() == 4), "R5", 64'(busy), 64'(mq.size() == 4));
      lbl = (!msg_ready && lag >= 3) ? "R3" : ((msg_ready && lag > 0) ? "R8" : "R2");
      chk(msg_valid == exp_v, lbl, 64'(msg_valid), 64'(exp_v));
      if (msg_valid && mq.size() != 0) begin
        chk(msg_data == mq[0], msg_ready ? "R6" : "R4", msg_data, mq[0]);
        if (win) void'(mq.pop_front());
      end
      if (req_valid && !busy) mq.push_back({req_data, req_tc, req_vec});
      lag = msg_ready ? 0 : (lag < 3 ? lag + 1 : 3);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_ni = 1'b0; req_valid = 0; req_vec = '0; req_tc = '0; req_data = '0; msg_ready = 1;
    repeat (3) @(negedge clk);
    chk(!msg_valid, "R7", 64'(msg_valid), 64'h0);
    chk(!busy, "R7", 64'(busy), 64'h0);
    step(); rst_ni = 1'b1;

    // table walk: one request at a time, field packing
    for (int i = 0; i < NV; i++) begin
      step();
      req_valid = 1; req_vec = T_VEC[i]; req_tc = T_TC[i]; req_data = T_DAT[i];
      step();
      req_valid = 0;
      @(negedge clk);
      chk(msg_valid && msg_data == T_EXP[i], "R1", msg_data, T_EXP[i]);
    end

    // back-to-back stream with ready high
    step();
    for (int i = 0; i < 12; i++) begin
      req_valid = 1; req_vec = 5'(i); req_tc = 3'(i); req_data = 56'(i * 32'h01010101);
      step();
    end
    req_valid = 0;
    step(); step();
    @(negedge clk);
    chk(!msg_valid, "R6", 64'(msg_valid), 64'h0);

    // stall past window, fill queue
    msg_ready = 0;
    repeat (5) step();
    for (int i = 0; i < 6; i++) begin
      req_valid = 1; req_vec = 5'(20 + i); req_tc = 3'(i); req_data = 56'(64'hDEAD00 + i);
      step();
    end
    req_valid = 0;
    @(negedge clk);
    chk(busy, "R5", 64'(busy), 64'h1);
    chk(!msg_valid, "R3", 64'(msg_valid), 64'h0);
    step();
    // one ready cycle then three grace cycles drain all four
    msg_ready = 1; step();
    msg_ready = 0;
    repeat (5) step();
    @(negedge clk);
    chk(!msg_valid, "R4", 64'(msg_valid), 64'h0);
    chk(!busy, "R4", 64'(busy), 64'h0);

    // irregular patterns
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        msg_ready = lf[0] | (lf[3] & lf[5]);
        req_valid = lf[7] | lf[2];
        req_vec = lf[12:8]; req_tc = lf[15:13]; req_data = {40'(i), lf};
        step();
      end
    end
    req_valid = 0; msg_ready = 1;
    repeat (8) step();

    // reset with pending requests
    msg_ready = 0;
    repeat (5) step();
    req_valid = 1; req_vec = 5'd7; req_tc = 3'd3; req_data = 56'hBEEF;
    step(); step();
    req_valid = 0;
    rst_ni = 0;
    mq.delete();
    @(negedge clk);
    chk(!msg_valid, "R7", 64'(msg_valid), 64'h0);
    chk(!busy, "R7", 64'(busy), 64'h0);
    step(); rst_ni = 1; msg_ready = 1;
    step();
    @(negedge clk);
    chk(!msg_valid, "R7", 64'(msg_valid), 64'h0);
    repeat (2) step();
    summary();
  end
endmodule